// File: doc/BRIEF.md
# Clock-Halt Reset and Resync Sequencer

This block decides when a converter's output samples may be trusted. It runs on a free-running reference clock and watches two slower clocks through synchronizers: the converter's system clock and its frame (sample-rate) clock. If the system clock stops, or the power-good input is low, the block holds the converter core in reset. It also signals power-down and forces the output data to zero.

Once the system clock runs again with power good, the release follows a fixed order. First a fixed number of system-clock edges pass with the core still in reset. Then a long run of frames passes with the data still zeroed. Only then is a fade-in requested.

While the core runs, the block compares the position of each frame edge against a free-running count of system-clock edges. A frame that shifts by more than a tolerance measured in bit clocks counts as a lost lock, and the data is zeroed at once. This also cuts short any fade in progress, since the fade is only allowed while data is not zeroed. Relock needs a frame whose shift is inside a tighter bound. After relock, the data is released following a much shorter settle.

Top module: `clk_halt_seq`

## Requirements
- R1: While rst_n is low, core_rst_n is 0, force_zero is 1, fade_start is 0 and power_down is 1.
- R2: While pwr_good is 0, power_down is 1 and core_rst_n is 0. When pwr_good rises with the system clock running, power_down drops within a few reference cycles.
- R3: With pwr_good high and the system clock running, core_rst_n rises after RST_SCK rising edges of sck_in. force_zero stays 1 at that moment.
- R4: After core_rst_n rises, force_zero stays 1 for LONG_FRAMES rising edges of frame_in. It then falls, and fade_start is 1 for exactly that one cycle. fade_start is never high at any other time.
- R5: If sck_in has no rising edge for HALT_CYC reference cycles, then in one cycle core_rst_n falls, force_zero rises and power_down rises. When edges return, power_down drops and the R3 and R4 sequence repeats in full.
- R6: Shift is the count of sck_in rising edges between two frame_in rising edges, modulo SCK_PER_FRAME, taken as the signed value nearest zero. When its magnitude exceeds 6 bit clocks (5 when BCK_PER_FRAME is 48) while running or settling, force_zero rises within a few cycles of that frame edge. This applies to both signs. One bit clock is SCK_PER_FRAME/BCK_PER_FRAME system-clock edges.
- R7: A shift of magnitude up to 6 bit clocks (5 for 48) while running has no effect: force_zero stays 0 and no output changes.
- R8: While lock is lost, a frame whose shift is 5 bit clocks or more (4 for 48) keeps lock lost. The first frame under that bound relocks. force_zero then stays 1 for SHORT_FRAMES further frame_in rising edges and falls with a fade_start pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_good | input | 1 | Supply-good level, synchronous to clk |
| sck_in | input | 1 | Converter system clock, sampled |
| frame_in | input | 1 | Frame (sample-rate) clock, sampled |
| core_rst_n | output | 1 | Active-low reset for the converter core |
| power_down | output | 1 | Power-down request (halt or no power) |
| force_zero | output | 1 | Output data must be zeroed |
| fade_start | output | 1 | One-cycle request to start a fade-in |

## Verification
Each input edge passes through a two-flop synchronizer and an edge register before any counter sees it. As a result, power_down follows pwr_good within about two cycles, and halt entry comes about HALT_CYC plus three cycles after the last sck_in rise. core_rst_n follows RST_SCK system-clock periods after the qualifying start, and each lock decision lands three to four cycles after the frame_in edge that caused it. The bench's driver queues every expected output transition together with a cycle window derived from these figures, taking the moment of the frame edge or clock stop it just caused as the reference. The monitor flags any transition that is not at the head of the queue, falls outside its window, or is a release without the fade pulse. Cases of no effect, such as tolerated shifts and the hysteresis frame, are confirmed by an empty queue and by sampling the levels a few frames later.

// File: rtl/chrs_pkg.sv
package chrs_pkg;
  typedef enum logic [1:0] {
    ST_RESET  = 2'd0,
    ST_SETTLE = 2'd1,
    ST_RUN    = 2'd2,
    ST_LOST   = 2'd3
  } seq_state_e;

  // Loss threshold in bit clocks (strictly greater loses lock)
  function automatic int lose_bck(input int bck_per_frame);
    return (bck_per_frame == 48) ? 5 : 6;
  endfunction

  // Relock threshold in bit clocks (strictly less relocks)
  function automatic int keep_bck(input int bck_per_frame);
    return (bck_per_frame == 48) ? 4 : 5;
  endfunction
endpackage

// File: rtl/chrs_sync.sv
module chrs_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] rise
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    logic [STAGES:0] sh_q;
    logic [STAGES:0] sh_d;

    always_comb sh_d = {sh_q[STAGES-1:0], async_in[i]};

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sh_q <= '0;
      else        sh_q <= sh_d;
    end

    assign rise[i] = sh_q[STAGES-1] & ~sh_q[STAGES];
  end
endmodule

// File: rtl/chrs_halt_det.sv
module chrs_halt_det #(
  parameter int HALT_CYC = 400
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sck_tick,
  output logic halted
);
  localparam int HW = $clog2(HALT_CYC + 1);
  localparam logic [HW-1:0] HALT_V = HW'(HALT_CYC);

  logic [HW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = sck_tick || (cnt_q != HALT_V);
    cnt_d  = sck_tick ? '0 : cnt_q + 1'b1;
  end

  // Starts saturated: no clock seen yet counts as halted
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= HALT_V;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign halted = (cnt_q == HALT_V);
endmodule

// File: rtl/chrs_phase_mon.sv
module chrs_phase_mon #(
  parameter int FRAME    = 256,
  parameter int LOSE_SCK = 24,
  parameter int KEEP_SCK = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic sck_tick,
  input  logic frm_tick,
  output logic edge_o,
  output logic slip_o,
  output logic lock_o
);
  localparam int PW = $clog2(FRAME);
  localparam int DW = PW + 1;
  localparam logic [DW-1:0] FRAME_V = DW'(FRAME);
  localparam logic [DW-1:0] HALF_V  = DW'(FRAME / 2);
  localparam logic [DW-1:0] LOSE_V  = DW'(LOSE_SCK);
  localparam logic [DW-1:0] KEEP_V  = DW'(KEEP_SCK);
  localparam logic [PW-1:0] LAST_V  = PW'(FRAME - 1);

  logic [PW-1:0] pos_q, pos_d, prev_q, prev_d;
  logic          have_q, have_d;
  logic          edge_q, edge_d, slip_q, slip_d, lock_q, lock_d;
  logic [DW-1:0] raw, diff, mag;
  logic          judge;

  always_comb begin
    pos_d = pos_q;
    if (sck_tick) pos_d = (pos_q == LAST_V) ? '0 : pos_q + 1'b1;
    raw    = {1'b0, pos_q} + FRAME_V - {1'b0, prev_q};
    diff   = (raw >= FRAME_V) ? raw - FRAME_V : raw;
    mag    = (diff > HALF_V) ? FRAME_V - diff : diff;
    judge  = frm_tick & have_q & ~clear;
    prev_d = frm_tick ? pos_q : prev_q;
    have_d = clear ? 1'b0 : (have_q | frm_tick);
    edge_d = frm_tick & ~clear;
    slip_d = judge & (mag > LOSE_V);
    lock_d = judge & (mag < KEEP_V);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q  <= '0;
      prev_q <= '0;
      have_q <= 1'b0;
      edge_q <= 1'b0;
      slip_q <= 1'b0;
      lock_q <= 1'b0;
    end else begin
      pos_q  <= pos_d;
      prev_q <= prev_d;
      have_q <= have_d;
      edge_q <= edge_d;
      slip_q <= slip_d;
      lock_q <= lock_d;
    end
  end

  assign edge_o = edge_q;
  assign slip_o = slip_q;
  assign lock_o = lock_q;
endmodule

// File: rtl/clk_halt_seq.sv
module clk_halt_seq
  import chrs_pkg::*;
#(
  parameter int SCK_PER_FRAME = 256,
  parameter int BCK_PER_FRAME = 64,
  parameter int RST_SCK       = 1024,
  parameter int LONG_FRAMES   = 8960,
  parameter int SHORT_FRAMES  = 32,
  parameter int HALT_CYC      = 400
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pwr_good,
  input  logic sck_in,
  input  logic frame_in,
  output logic core_rst_n,
  output logic power_down,
  output logic force_zero,
  output logic fade_start
);
  localparam int SCK_PER_BCK = SCK_PER_FRAME / BCK_PER_FRAME;
  localparam int LOSE_SCK    = lose_bck(BCK_PER_FRAME) * SCK_PER_BCK;
  localparam int KEEP_SCK    = keep_bck(BCK_PER_FRAME) * SCK_PER_BCK;
  localparam int RW          = $clog2(RST_SCK + 1);
  localparam int FMAX        = (LONG_FRAMES > SHORT_FRAMES) ? LONG_FRAMES : SHORT_FRAMES;
  localparam int FW          = $clog2(FMAX + 1);
  localparam logic [RW-1:0] RST_LAST   = RW'(RST_SCK - 1);
  localparam logic [FW-1:0] LONG_LAST  = FW'(LONG_FRAMES - 1);
  localparam logic [FW-1:0] SHORT_LAST = FW'(SHORT_FRAMES - 1);

  // Reset: asserted asynchronously, released on clk
  logic [1:0] rs_q;
  logic       irst_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign irst_n = rs_q[1];

  logic [1:0] rise;
  logic       sck_tick, frm_tick, halted;
  logic       ph_edge, ph_slip, ph_lock;
  seq_state_e st_q, st_d;

  chrs_sync #(.WIDTH(2), .STAGES(2)) u_sync (
    .clk(clk), .rst_n(irst_n), .async_in({frame_in, sck_in}), .rise(rise)
  );
  assign sck_tick = rise[0];
  assign frm_tick = rise[1];

  chrs_halt_det #(.HALT_CYC(HALT_CYC)) u_halt (
    .clk(clk), .rst_n(irst_n), .sck_tick(sck_tick), .halted(halted)
  );

  chrs_phase_mon #(
    .FRAME(SCK_PER_FRAME), .LOSE_SCK(LOSE_SCK), .KEEP_SCK(KEEP_SCK)
  ) u_phase (
    .clk(clk), .rst_n(irst_n), .clear(st_q == ST_RESET),
    .sck_tick(sck_tick), .frm_tick(frm_tick),
    .edge_o(ph_edge), .slip_o(ph_slip), .lock_o(ph_lock)
  );

  logic [RW-1:0] rc_q, rc_d;
  logic [FW-1:0] fc_q, fc_d, fc_last;
  logic          short_q, short_d, pd_q, pd_d, fade_q, fade_d;

  always_comb begin
    st_d    = st_q;
    rc_d    = rc_q;
    fc_d    = fc_q;
    short_d = short_q;
    fc_last = short_q ? SHORT_LAST : LONG_LAST;
    if (halted || !pwr_good) begin
      st_d = ST_RESET;
      rc_d = '0;
    end else begin
      unique case (st_q)
        ST_RESET: if (sck_tick) begin
          if (rc_q == RST_LAST) begin
            st_d    = ST_SETTLE;
            rc_d    = '0;
            fc_d    = '0;
            short_d = 1'b0;
          end else begin
            rc_d = rc_q + 1'b1;
          end
        end
        ST_SETTLE: begin
          if (ph_slip)                 st_d = ST_LOST;
          else if (ph_edge) begin
            if (fc_q == fc_last)       st_d = ST_RUN;
            else                       fc_d = fc_q + 1'b1;
          end
        end
        ST_RUN:  if (ph_slip) st_d = ST_LOST;
        ST_LOST: if (ph_lock) begin
          st_d    = ST_SETTLE;
          fc_d    = '0;
          short_d = 1'b1;
        end
        default: st_d = ST_RESET;
      endcase
    end
    pd_d   = halted | ~pwr_good;
    fade_d = (st_q == ST_SETTLE) && (st_d == ST_RUN);
  end

  always_ff @(posedge clk or negedge irst_n) begin
    if (!irst_n) begin
      st_q    <= ST_RESET;
      rc_q    <= '0;
      fc_q    <= '0;
      short_q <= 1'b0;
      pd_q    <= 1'b1;
      fade_q  <= 1'b0;
    end else begin
      st_q    <= st_d;
      rc_q    <= rc_d;
      fc_q    <= fc_d;
      short_q <= short_d;
      pd_q    <= pd_d;
      fade_q  <= fade_d;
    end
  end

  assign core_rst_n = (st_q != ST_RESET);
  assign force_zero = (st_q != ST_RUN);
  assign power_down = pd_q;
  assign fade_start = fade_q;
endmodule

// File: rtl/clk_halt_seq_chk.sv
module clk_halt_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic pwr_good,
  input logic core_rst_n,
  input logic power_down,
  input logic force_zero,
  input logic fade_start
);
  a_r2_pg_low_holds_reset: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_good |=> (!core_rst_n && power_down));

  a_r5_pd_forces_reset_zero: assert property (@(posedge clk) disable iff (!rst_n)
    power_down |-> (!core_rst_n && force_zero));

  a_r3_reset_keeps_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !core_rst_n |-> force_zero);

  a_r3_release_still_zero: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(core_rst_n) |-> force_zero);

  a_r4_fade_at_release: assert property (@(posedge clk) disable iff (!rst_n)
    fade_start |-> (!force_zero && $past(force_zero)));

  a_r4_release_has_fade: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(force_zero) |-> fade_start);

  a_r8_fade_single: assert property (@(posedge clk) disable iff (!rst_n)
    fade_start |=> !fade_start);
endmodule

bind clk_halt_seq clk_halt_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .pwr_good(pwr_good), .core_rst_n(core_rst_n),
  .power_down(power_down), .force_zero(force_zero), .fade_start(fade_start)
);

// File: tb/clk_halt_seq_bench.sv
module clk_halt_seq_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NRM    = 64;
  localparam int RSTN   = 32;
  localparam int LONGN  = 40;
  localparam int SHORTN = 8;
  localparam int HALTN  = 24;
  localparam int FRM_CYC = NRM * 4;

  localparam int EV_REL = 0, EV_RST = 1, EV_FZ_ON = 2, EV_FZ_OFF = 3, EV_PD_ON = 4, EV_PD_OFF = 5;

  typedef struct {
    int    kind;
    int    lo;
    int    hi;
    string req;
  } exp_t;

  logic clk, rst_n, pwr_good, sck_in, frame_in;
  logic core_rst_n, power_down, force_zero, fade_start;

  exp_t expq[$];
  int   cyc, checks, fails, last_rise, cur_len, pend_len, fcnt, sub, t0, t;
  bit   run, mon_on;
  logic p_rst, p_fz, p_pd;

  clk_halt_seq #(
    .SCK_PER_FRAME(NRM), .BCK_PER_FRAME(64), .RST_SCK(RSTN),
    .LONG_FRAMES(LONGN), .SHORT_FRAMES(SHORTN), .HALT_CYC(HALTN)
  ) u_clk_halt_seq (
    .clk(clk), .rst_n(rst_n), .pwr_good(pwr_good), .sck_in(sck_in),
    .frame_in(frame_in), .core_rst_n(core_rst_n), .power_down(power_down),
    .force_zero(force_zero), .fade_start(fade_start)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic expect_ev(input int kind, input int lo, input int hi, input string req);
    expq.push_back('{kind: kind, lo: lo, hi: hi, req: req});
  endtask

  task automatic take(input int kind);
    exp_t e;
    if (expq.size() == 0) begin
      check(1'b0, "R7", "unexpected output event", kind, -1);
    end else begin
      e = expq.pop_front();
      check(e.kind == kind, e.req, "event kind", kind, e.kind);
      check(cyc >= e.lo && cyc <= e.hi, e.req, "event cycle", cyc, e.lo);
      if (kind == EV_FZ_OFF) check(fade_start == 1'b1, "R4", "fade_start at release", fade_start, 1);
    end
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  initial begin
    clk = 1'b0;
    forever #(CLK_PERIOD / 2) clk = ~clk;
  end

  initial begin
    cyc = 0;
    forever begin
      @(posedge clk);
      cyc++;
    end
  end

  // System and frame clock generator: sck period 4 reference cycles
  initial begin
    sck_in = 1'b0; frame_in = 1'b0; sub = 0; fcnt = 0;
    cur_len = NRM; pend_len = NRM; last_rise = 0;
    forever begin
      @(negedge clk);
      if (run) begin
        if (sub == 0) begin
          sck_in = 1'b1;
          last_rise = cyc;
          fcnt++;
          if (fcnt == cur_len) begin
            fcnt = 0;
            cur_len = pend_len;
            pend_len = NRM;
            frame_in = 1'b1;
          end else if (fcnt == 32) begin
            frame_in = 1'b0;
          end
        end else if (sub == 2) begin
          sck_in = 1'b0;
        end
        sub = (sub + 1) % 4;
      end
    end
  end

  // Monitor: every output transition must match the head of the queue
  initial begin
    wait (mon_on);
    p_rst = core_rst_n; p_fz = force_zero; p_pd = power_down;
    forever begin
      @(negedge clk);
      if (core_rst_n !== p_rst) take(core_rst_n ? EV_REL : EV_RST);
      if (force_zero !== p_fz)  take(force_zero ? EV_FZ_ON : EV_FZ_OFF);
      if (power_down !== p_pd)  take(power_down ? EV_PD_ON : EV_PD_OFF);
      if (fade_start && !(p_fz && !force_zero))
        check(1'b0, "R4", "fade_start outside release", 1, 0);
      p_rst = core_rst_n; p_fz = force_zero; p_pd = power_down;
    end
  end

  initial begin
    repeat (120000) @(posedge clk);
    check(1'b0, "R3", "watchdog expired", cyc, 0);
    summary();
    $finish;
  end

  initial begin
    checks = 0; fails = 0; mon_on = 1'b0; run = 1'b0;
    rst_n = 1'b0; pwr_good = 1'b0;
    repeat (5) @(negedge clk);
    check(core_rst_n == 1'b0, "R1", "core_rst_n in reset", core_rst_n, 0);
    check(force_zero == 1'b1, "R1", "force_zero in reset", force_zero, 1);
    check(fade_start == 1'b0, "R1", "fade_start in reset", fade_start, 0);
    check(power_down == 1'b1, "R1", "power_down in reset", power_down, 1);
    rst_n = 1'b1;
    run = 1'b1;
    repeat (3) @(negedge clk);
    mon_on = 1'b1;

    // R2: clocks run but power is not good
    repeat (300) @(negedge clk);
    check(core_rst_n == 1'b0, "R2", "core held while power bad", core_rst_n, 0);
    check(power_down == 1'b1, "R2", "power_down while power bad", power_down, 1);

    // R3/R4: power-on release sequence
    pwr_good = 1'b1; t0 = cyc;
    expect_ev(EV_PD_OFF, t0, t0 + 4, "R2");
    expect_ev(EV_REL, t0 + RSTN * 4 - 10, t0 + RSTN * 4 + 12, "R3");
    @(posedge core_rst_n);
    @(posedge frame_in); t = cyc;
    expect_ev(EV_FZ_OFF, t + (LONGN - 2) * FRM_CYC, t + (LONGN - 1) * FRM_CYC + 12, "R4");
    @(negedge force_zero);
    repeat (4) @(negedge clk);
    check(expq.size() == 0, "R4", "pending events after power-on", expq.size(), 0);

    // R7: tolerated shifts of +5 and -5 bit clocks
    @(posedge frame_in); pend_len = NRM + 5;
    @(posedge frame_in); @(posedge frame_in);
    repeat (12) @(negedge clk);
    check(force_zero == 1'b0, "R7", "force_zero after +5 shift", force_zero, 0);
    @(posedge frame_in); pend_len = NRM - 5;
    @(posedge frame_in); @(posedge frame_in);
    repeat (12) @(negedge clk);
    check(force_zero == 1'b0, "R7", "force_zero after -5 shift", force_zero, 0);

    // R6/R8: +10 loss, then a +5 frame that must not relock
    @(posedge frame_in); pend_len = NRM + 10;
    @(posedge frame_in); pend_len = NRM + 5;
    @(posedge frame_in); t = cyc;
    expect_ev(EV_FZ_ON, t, t + 8, "R6");
    @(posedge frame_in);
    repeat (12) @(negedge clk);
    check(force_zero == 1'b1, "R8", "still lost after 5-bck frame", force_zero, 1);
    @(posedge frame_in); t = cyc;
    expect_ev(EV_FZ_OFF, t + SHORTN * FRM_CYC - 2, t + SHORTN * FRM_CYC + 10, "R8");
    @(negedge force_zero);
    repeat (4) @(negedge clk);
    check(expq.size() == 0, "R8", "pending events after resync", expq.size(), 0);

    // R6: negative shift of 10 bit clocks
    @(posedge frame_in); pend_len = NRM - 10;
    @(posedge frame_in);
    @(posedge frame_in); t = cyc;
    expect_ev(EV_FZ_ON, t, t + 8, "R6");
    @(posedge frame_in); t = cyc;
    expect_ev(EV_FZ_OFF, t + SHORTN * FRM_CYC - 2, t + SHORTN * FRM_CYC + 10, "R8");
    @(negedge force_zero);
    repeat (4) @(negedge clk);

    // R5: system clock halt and resume
    run = 1'b0; t = last_rise;
    expect_ev(EV_RST, t + HALTN - 6, t + HALTN + 12, "R5");
    expect_ev(EV_FZ_ON, t + HALTN - 6, t + HALTN + 12, "R5");
    expect_ev(EV_PD_ON, t + HALTN - 6, t + HALTN + 12, "R5");
    repeat (150) @(negedge clk);
    check(core_rst_n == 1'b0, "R5", "core held while halted", core_rst_n, 0);
    check(power_down == 1'b1, "R5", "power_down while halted", power_down, 1);
    run = 1'b1; t0 = cyc;
    expect_ev(EV_PD_OFF, t0, t0 + 10, "R5");
    expect_ev(EV_REL, t0 + RSTN * 4 - 8, t0 + RSTN * 4 + 20, "R5");
    @(posedge core_rst_n);
    @(posedge frame_in); t = cyc;
    expect_ev(EV_FZ_OFF, t + (LONGN - 2) * FRM_CYC, t + (LONGN - 1) * FRM_CYC + 12, "R5");
    @(negedge force_zero);
    repeat (6) @(negedge clk);
    check(expq.size() == 0, "R5", "pending events at end", expq.size(), 0);
    summary();
    $finish;
  end
endmodule